// File: doc/BRIEF.md
# Buffer Event Status Register

This block holds the event flags of a network interface's transmit and receive buffers. Other logic sends it single-cycle pulses: a software-requested interrupt, transmitter ready for a frame, transmit underrun, a lost receive frame, and a destination address match. The block keeps each pulse as a sticky flag until software reads the register. Every read clears all flags. The value read always carries a fixed six-bit register identifier in its low bits.

A separate configuration register input supplies one enable per event, at the same bit position as the event. The registered interrupt output is high while any set flag has its enable high.

The early-receive flag comes from inside the block. A byte-count state machine has three states. CNT_IDLE means no frame is open. CNT_RUN counts byte strobes. CNT_DONE means the mark was reached and the count is held. The transitions are:
- start-of-frame moves CNT_IDLE to CNT_RUN, and also moves CNT_DONE to CNT_RUN.
- start-of-frame while in CNT_RUN restarts the count and stays in CNT_RUN.
- the 128th strobe moves CNT_RUN to CNT_DONE and fires the flag.
- in CNT_DONE and CNT_IDLE, strobes are ignored.

Top module: `buf_event_reg`

## Requirements
- R1: `rd_data[5:0]` always equals 6'b001100.
- R2: After reset, `rd_data` is 16'h000C and `irq` is low.
- R3: A one-cycle pulse sets its flag, and the flag reads as set from the next cycle on. The flag positions are: software 6, transmit ready 8, transmit underrun 9, receive missed 10, 128 bytes received 11, destination match 15.
- R4: Bits 7, 12, 13 and 14 of `rd_data` always read zero, whatever the inputs or `cfg_word` are.
- R5: A cycle with `rd_en` high clears every flag at that clock edge.
- R6: A pulse that arrives in the same cycle as `rd_en` leaves its flag set after the clear.
- R7: After `rx_sof`, the 128th `rx_byte` strobe sets bit 11, and the 127th strobe does not.
- R8: Bit 11 sets at most once per frame. Further strobes in that frame, and strobes before any `rx_sof`, do not set it.
- R9: An `rx_sof` in the middle of a frame restarts the byte count from zero.
- R10: `irq` is a register that is high one cycle after any flag is set whose `cfg_word` bit at the same position is high. `cfg_word` bits 0-5, 7 and 12-14 have no effect.
- R11: `irq` falls one cycle after the read that clears the last enabled flag.
- R12: If a destination match pulse comes before the 128th byte, bit 15 reads set while bit 11 is still clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe; clears flags |
| sw_int_pulse | input | 1 | Software interrupt request |
| tx_ready_pulse | input | 1 | Transmitter ready for a frame |
| tx_underrun_pulse | input | 1 | Transmit data ran out early |
| rx_miss_pulse | input | 1 | Receive frame lost |
| rx_dest_pulse | input | 1 | Destination address matched |
| rx_sof | input | 1 | Start of a receive frame |
| rx_byte | input | 1 | One receive byte arrived |
| cfg_word | input | 16 | Interrupt enables, same positions as the flags |
| rd_data | output | 16 | Register value |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench checks the read that coincides with a new pulse: a design that clears unconditionally loses that event. It checks the byte count at 127 and at 128 strobes, and sends long runs of strobes after the mark and before any start-of-frame. An off-by-one counter, a counter that wraps, or one that runs when no frame is open shows up here as a wrong flag. A start-of-frame in mid-frame is checked to restart the count. Enables placed on reserved positions are checked to raise no interrupt. The fall of `irq` is timed to the exact cycle.

// File: rtl/buf_evt_pkg.sv
package buf_evt_pkg;
    localparam int REG_W = 16;
    localparam logic [5:0] REG_ID = 6'b001100;
    localparam int POS_SW  = 6;
    localparam int POS_RDY = 8;
    localparam int POS_UND = 9;
    localparam int POS_MIS = 10;
    localparam int POS_128 = 11;
    localparam int POS_DST = 15;
    localparam logic [REG_W-1:0] EVT_MASK =
        (16'd1 << POS_SW) | (16'd1 << POS_RDY) | (16'd1 << POS_UND) |
        (16'd1 << POS_MIS) | (16'd1 << POS_128) | (16'd1 << POS_DST);

    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_DONE = 2'd2
    } cnt_state_e;
endpackage

// File: rtl/rx_byte_fsm.sv
module rx_byte_fsm
    import buf_evt_pkg::*;
#(
    parameter int FRAME_MARK = 128,
    localparam int CNT_W = $clog2(FRAME_MARK + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic byte_stb,
    output logic fire
);
    cnt_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_MARK - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            CNT_IDLE: begin
                if (sof) begin
                    state_d = CNT_RUN;
                    cnt_d   = '0;
                end
            end
            CNT_RUN: begin
                if (sof) begin
                    cnt_d = '0;
                end else if (byte_stb) begin
                    if (cnt_q == LAST) begin
                        fire    = 1'b1;
                        state_d = CNT_DONE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            CNT_DONE: begin
                if (sof) begin
                    state_d = CNT_RUN;
                    cnt_d   = '0;
                end
            end
            default: state_d = CNT_IDLE;
        endcase
    end

    p_fire_to_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> state_q == CNT_DONE);
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_sof_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (cnt_q == '0 && state_q == CNT_RUN));
endmodule

// File: rtl/evt_latch.sv
module evt_latch #(
    parameter int W = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_in,
    input  logic         clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_flop
            logic f_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         f_q <= 1'b0;
                else if (set_in[i]) f_q <= 1'b1;
                else if (clr)       f_q <= 1'b0;
            end
            assign q[i] = f_q;

            p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && !set_in[i]) |=> !q[i]);
            p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
                set_in[i] |=> q[i]);
        end else begin : g_zero
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
    parameter int W = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] en,
    output logic         irq
);
    logic irq_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(evt & en & MASK);
    end
    assign irq = irq_q;
endmodule

// File: rtl/buf_event_reg.sv
module buf_event_reg
    import buf_evt_pkg::*;
#(
    parameter int FRAME_MARK = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        sw_int_pulse,
    input  logic        tx_ready_pulse,
    input  logic        tx_underrun_pulse,
    input  logic        rx_miss_pulse,
    input  logic        rx_dest_pulse,
    input  logic        rx_sof,
    input  logic        rx_byte,
    input  logic [15:0] cfg_word,
    output logic [15:0] rd_data,
    output logic        irq
);
    logic             hit128;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] evt_q;

    rx_byte_fsm #(.FRAME_MARK(FRAME_MARK)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sof(rx_sof), .byte_stb(rx_byte), .fire(hit128)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[POS_SW]  = sw_int_pulse;
        set_vec[POS_RDY] = tx_ready_pulse;
        set_vec[POS_UND] = tx_underrun_pulse;
        set_vec[POS_MIS] = rx_miss_pulse;
        set_vec[POS_128] = hit128;
        set_vec[POS_DST] = rx_dest_pulse;
    end

    evt_latch #(.W(REG_W), .MASK(EVT_MASK)) u_latch (
        .clk(clk), .rst_n(rst_n), .set_in(set_vec), .clr(rd_en), .q(evt_q)
    );

    irq_gen #(.W(REG_W), .MASK(EVT_MASK)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt_q), .en(cfg_word), .irq(irq)
    );

    assign rd_data = evt_q | {{(REG_W-6){1'b0}}, REG_ID};

    p_irq_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && set_vec == '0) |-> ##2 !irq);
    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0 && rd_data[14:12] == 3'b000);
endmodule

// File: tb/buf_event_reg_bench.sv
module buf_event_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        sw_int_pulse = 1'b0, tx_ready_pulse = 1'b0, tx_underrun_pulse = 1'b0;
    logic        rx_miss_pulse = 1'b0, rx_dest_pulse = 1'b0, rx_sof = 1'b0, rx_byte = 1'b0;
    logic [15:0] cfg_word = 16'h0000;
    logic [15:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    buf_event_reg u_buf_event_reg (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .sw_int_pulse(sw_int_pulse), .tx_ready_pulse(tx_ready_pulse),
        .tx_underrun_pulse(tx_underrun_pulse), .rx_miss_pulse(rx_miss_pulse),
        .rx_dest_pulse(rx_dest_pulse), .rx_sof(rx_sof), .rx_byte(rx_byte),
        .cfg_word(cfg_word), .rd_data(rd_data), .irq(irq)
    );

    // {rd, sw, rdy, und, miss, dest, cfg[15:0], exp_data[15:0], exp_irq}
    localparam int NV = 8;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 5'b10000, 16'h0000, 16'h004C, 1'b0},  // R3 software bit 6
        {1'b0, 5'b01000, 16'h0040, 16'h014C, 1'b1},  // R3 R10 ready bit 8
        {1'b1, 5'b00000, 16'h0040, 16'h000C, 1'b0},  // R5 read clears
        {1'b0, 5'b00110, 16'h7080, 16'h060C, 1'b0},  // R3 R10 R4 reserved enables
        {1'b1, 5'b00001, 16'h8000, 16'h800C, 1'b1},  // R6 pulse during read
        {1'b1, 5'b00000, 16'h8000, 16'h000C, 1'b0},  // R5 R11
        {1'b0, 5'b11111, 16'h0600, 16'h874C, 1'b1},  // R3 all sources
        {1'b1, 5'b00000, 16'hFFFF, 16'h000C, 1'b0}   // R5 R4 full enables
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin
            rx_byte = 1'b1;
            @(negedge clk);
        end
        rx_byte = 1'b0;
    endtask

    task automatic sof_pulse();
        rx_sof = 1'b1;
        @(negedge clk);
        rx_sof = 1'b0;
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset data", rd_data, 16'h000C);
        chk("R2 reset irq", {15'd0, irq}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 id bits", {10'd0, rd_data[5:0]}, 16'h000C);

        for (int v = 0; v < NV; v++) begin
            {rd_en, sw_int_pulse, tx_ready_pulse, tx_underrun_pulse, rx_miss_pulse,
             rx_dest_pulse, cfg_word} = VEC[v][38:17];
            @(negedge clk);
            {rd_en, sw_int_pulse, tx_ready_pulse, tx_underrun_pulse, rx_miss_pulse,
             rx_dest_pulse} = '0;
            chk($sformatf("R3 R5 R6 vector %0d data", v), rd_data, VEC[v][16:1]);
            @(negedge clk);
            chk($sformatf("R10 vector %0d irq", v), {15'd0, irq}, {15'd0, VEC[v][0]});
        end

        // R11: exact fall timing of irq
        cfg_word = 16'h0100;
        tx_ready_pulse = 1'b1;
        @(negedge clk);
        tx_ready_pulse = 1'b0;
        @(negedge clk);
        chk("R11 irq high before read", {15'd0, irq}, 16'd1);
        do_read();
        chk("R11 irq still high right after read", {15'd0, irq}, 16'd1);
        @(negedge clk);
        chk("R11 irq low one cycle after read", {15'd0, irq}, 16'd0);

        // R8: strobes with no open frame
        cfg_word = 16'h0800;
        bytes(140);
        chk("R8 no count before sof", rd_data, 16'h000C);

        // R7 R12: 127 vs 128, with destination match early
        sof_pulse();
        bytes(19);
        rx_dest_pulse = 1'b1;
        rx_byte = 1'b1;
        @(negedge clk);
        rx_dest_pulse = 1'b0;
        rx_byte = 1'b0;
        chk("R12 dest set while 128 clear", rd_data & 16'h8800, 16'h8000);
        bytes(107);
        chk("R7 127 bytes no flag", rd_data & 16'h0800, 16'h0000);
        bytes(1);
        chk("R7 128th byte sets flag", rd_data, 16'h880C);
        @(negedge clk);
        chk("R10 irq from bit 11", {15'd0, irq}, 16'd1);

        // R8: once per frame
        do_read();
        bytes(200);
        chk("R8 no second flag in frame", rd_data, 16'h000C);

        // R9: restart mid-frame
        sof_pulse();
        bytes(100);
        sof_pulse();
        bytes(100);
        chk("R9 count restarted", rd_data, 16'h000C);
        bytes(28);
        chk("R9 flag after 128 since restart", rd_data, 16'h080C);
        chk("R4 reserved bits zero", rd_data & 16'h7080, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule